// File: doc/BRIEF.md
# Bus-Programmed Bicolour LED Pattern Controller

This block drives one bicolour (blue/red) front indicator and five bicolour drive-status indicators. A host programs it over a narrow parallel bus: a 3-bit address, a 3-bit data word and a single strobe. Each rising edge of the strobe stores the data word in one of eight registers. Six of these registers are mode registers, one for each LED. The other two set the brightness of the front LED and the brightness shared by all drive LEDs.

A mode picks one of these behaviours:
- steady off, steady blue or steady red;
- a timed blink pattern built from half-second steps;
- for a drive LED only, a blue blink that follows that drive's active-low activity input.

A free-running tick derived from the system clock (parameter `CLK_HZ`) sets the timing of all patterns. Brightness is an 8-level PWM gate applied after the pattern has been chosen. The three bus inputs and the activity inputs are asynchronous. Each is passed through a two-flop synchroniser before use.

Top module: `led_pattern_ctrl`

## Requirements
- R1: A register is written exactly once for each rising edge of `bus_en`. The write uses the address and data present at that edge, both synchronised by two flops. Changing `bus_addr` or `bus_data` while `bus_en` stays high writes nothing.
- R2: Address decoding:
  - address 0 is the front mode;
  - address 1 is the front brightness;
  - address 2 is the drive brightness;
  - addresses 3, 4, 5, 6 and 7 are the modes of drives 0 to 4, in that order.
  A write changes only the register it addresses.
- R3: After reset, every mode register is 0 and every output is low. Both brightness registers are 7.
- R4: Front LED modes: 0 is off, 1 is steady blue, 2 is steady red.
- R5: Timed modes, with H standing for half a second (CLK_HZ/2 cycles):
  - mode 3 is blue for 2H, then off for 2H;
  - mode 4 is red for 2H, then off for 2H;
  - mode 5 is blue for 5H, then red for 1H;
  - mode 6 is blue for 2H, then red for 2H;
  - mode 7 (front LED only) is blue for 1H, then off for 5H.
  These modes work the same way on the front LED and on the drive LEDs.
- R6: Any write to a mode register restarts that LED's pattern at its first phase. The first phase then lasts between 1 and H cycles.
- R7: Drive LED modes: 0 is off, 1 follows activity, 2 is steady red, 7 is steady blue.
- R8: In mode 1, a drive LED responds to activity as follows:
  - a low level on its activity input, even for one cycle, gives blue for CLK_HZ/20 cycles and then off for CLK_HZ/20 cycles;
  - activity that is still present at the end of the off time restarts the blink at once;
  - activity on one drive does not light any other drive.
- R9: Brightness L (0 to 7) keeps an LED's output on for L cycles out of every 7-cycle frame. A brightness of 0 is always off and 7 is always on.
- R10: No LED drives blue and red in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address (asynchronous) |
| bus_data | input | 3 | Register write data (asynchronous) |
| bus_en | input | 1 | Write strobe; the rising edge writes |
| act_n | input | 5 | Per-drive activity, active low, bit i for drive i |
| front_blue | output | 1 | Front LED blue drive |
| front_red | output | 1 | Front LED red drive |
| drv_blue | output | 5 | Drive LED blue drives, bit i for drive i |
| drv_red | output | 5 | Drive LED red drives, bit i for drive i |

## Verification
The assertions check on every cycle that:
- each strobe edge gives a single write pulse;
- the tick and the PWM frame counter wrap correctly;
- a mode write sets the phase back to zero;
- brightness 0 and mode 0 hold an LED dark;
- no LED shows both colours at once.

Only the bench scenarios can show the rest:
- the duty totals of each timed pattern over a whole period;
- the PWM ratio at intermediate brightness levels;
- the length of the activity blink;
- the address decoding;
- that a data change while the strobe is held high is ignored.

// File: rtl/ledctl_pkg.sv
package ledctl_pkg;

    localparam int FIELD_W = 3;
    localparam int PHASE_W = 3;

    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,
        ACT_ON   = 2'd1,
        ACT_OFF  = 2'd2
    } act_st_e;

    // Index of the last half-second phase of a pattern (period - 1).
    function automatic logic [PHASE_W-1:0] last_phase(input logic [FIELD_W-1:0] mode);
        if (mode == 3'd5 || mode == 3'd7) return 3'd5;
        return 3'd3;
    endfunction

    // Returns {red, blue} for a mode, phase and LED kind.
    function automatic logic [1:0] pattern_colour(input logic [FIELD_W-1:0] mode,
                                                  input logic [PHASE_W-1:0] ph,
                                                  input logic               is_drive,
                                                  input logic               act_lit);
        logic [1:0] rb;
        case (mode)
            3'd0:    rb = 2'b00;
            3'd1:    rb = is_drive ? {1'b0, act_lit} : 2'b01;
            3'd2:    rb = 2'b10;
            3'd3:    rb = {1'b0, (ph < 3'd2)};
            3'd4:    rb = {(ph < 3'd2), 1'b0};
            3'd5:    rb = {(ph == 3'd5), (ph != 3'd5)};
            3'd6:    rb = {(ph >= 3'd2), (ph < 3'd2)};
            default: rb = is_drive ? 2'b01 : {1'b0, (ph == 3'd0)};
        endcase
        return rb;
    endfunction

endpackage

// File: rtl/ledctl_bus_sync.sv
module ledctl_bus_sync #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_en,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    typedef struct packed {
        logic [ADDR_W-1:0] a1;
        logic [ADDR_W-1:0] a2;
        logic [DATA_W-1:0] d1;
        logic [DATA_W-1:0] d2;
        logic              e1;
        logic              e2;
        logic              e3;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.a1 = bus_addr;
        sync_d.a2 = sync_q.a1;
        sync_d.d1 = bus_data;
        sync_d.d2 = sync_q.d1;
        sync_d.e1 = bus_en;
        sync_d.e2 = sync_q.e1;
        sync_d.e3 = sync_q.e2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign wr_en   = sync_q.e2 & ~sync_q.e3;
    assign wr_addr = sync_q.a2;
    assign wr_data = sync_q.d2;

    // R1
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

endmodule

// File: rtl/ledctl_timebase.sv
module ledctl_timebase #(
    parameter int CLK_HZ    = 100_000_000,
    parameter int PWM_STEPS = 7,
    parameter int PWM_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             tick,
    output logic [PWM_W-1:0] pwm_cnt
);

    localparam int HALF_CYC = CLK_HZ / 2;
    localparam int CNT_W    = $clog2(HALF_CYC);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PWM_W-1:0] pwm;
        logic             tick;
    } tb_t;

    tb_t tb_d, tb_q;

    always_comb begin
        tb_d      = tb_q;
        tb_d.tick = 1'b0;
        if (tb_q.cnt == CNT_W'(HALF_CYC - 1)) begin
            tb_d.cnt  = '0;
            tb_d.tick = 1'b1;
        end else begin
            tb_d.cnt = tb_q.cnt + CNT_W'(1);
        end
        if (tb_q.pwm == PWM_W'(PWM_STEPS - 1)) tb_d.pwm = '0;
        else                                   tb_d.pwm = tb_q.pwm + PWM_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end

    assign tick    = tb_q.tick;
    assign pwm_cnt = tb_q.pwm;

    // R5
    tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R9
    pwm_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_cnt == PWM_W'(PWM_STEPS - 1)) |=> (pwm_cnt == '0));

endmodule

// File: rtl/ledctl_channel.sv
module ledctl_channel
    import ledctl_pkg::*;
#(
    parameter bit IS_DRIVE    = 1'b0,
    parameter int STRETCH_CYC = 5_000_000,
    parameter int PWM_W       = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [PWM_W-1:0]   pwm_cnt,
    input  logic               mode_wr,
    input  logic [FIELD_W-1:0] wr_data,
    input  logic [FIELD_W-1:0] level,
    input  logic               act_n,
    output logic               blue_o,
    output logic               red_o
);

    localparam int SW = $clog2(STRETCH_CYC + 1);

    typedef struct packed {
        logic [FIELD_W-1:0] mode;
        logic [PHASE_W-1:0] phase;
        act_st_e            act_st;
        logic [SW-1:0]      act_cnt;
        logic               as1;
        logic               as2;
        logic               blue;
        logic               red;
    } ch_t;

    ch_t ch_d, ch_q;
    logic [1:0] colour;
    logic       gate;

    always_comb begin
        ch_d     = ch_q;
        ch_d.as1 = ~act_n;
        ch_d.as2 = ch_q.as1;

        // pattern phase in half-second steps
        if (mode_wr) begin
            ch_d.mode  = wr_data;
            ch_d.phase = '0;
        end else if (tick) begin
            if (ch_q.phase >= last_phase(ch_q.mode)) ch_d.phase = '0;
            else                                     ch_d.phase = ch_q.phase + 3'd1;
        end

        // activity stretcher
        case (ch_q.act_st)
            ACT_IDLE: begin
                ch_d.act_cnt = '0;
                if (ch_q.as2) ch_d.act_st = ACT_ON;
            end
            ACT_ON: begin
                if (ch_q.act_cnt == SW'(STRETCH_CYC - 1)) begin
                    ch_d.act_st  = ACT_OFF;
                    ch_d.act_cnt = '0;
                end else begin
                    ch_d.act_cnt = ch_q.act_cnt + SW'(1);
                end
            end
            ACT_OFF: begin
                if (ch_q.act_cnt == SW'(STRETCH_CYC - 1)) begin
                    ch_d.act_st  = ch_q.as2 ? ACT_ON : ACT_IDLE;
                    ch_d.act_cnt = '0;
                end else begin
                    ch_d.act_cnt = ch_q.act_cnt + SW'(1);
                end
            end
            default: begin
                ch_d.act_st  = ACT_IDLE;
                ch_d.act_cnt = '0;
            end
        endcase

        colour    = pattern_colour(ch_q.mode, ch_q.phase, IS_DRIVE, ch_q.act_st == ACT_ON);
        gate      = (pwm_cnt < level);
        ch_d.blue = colour[0] & gate;
        ch_d.red  = colour[1] & gate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q        <= '0;
            ch_q.act_st <= ACT_IDLE;
        end else begin
            ch_q <= ch_d;
        end
    end

    assign blue_o = ch_q.blue;
    assign red_o  = ch_q.red;

    // R6
    phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (ch_q.phase == '0));

    // R10
    one_colour_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(blue_o && red_o));

    // R9
    dark_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) |=> (!blue_o && !red_o));

    // R3
    mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_q.mode == '0) |=> (!blue_o && !red_o));

endmodule

// File: rtl/led_pattern_ctrl.sv
module led_pattern_ctrl
    import ledctl_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   bus_addr,
    input  logic [2:0]   bus_data,
    input  logic         bus_en,
    input  logic [4:0]   act_n,
    output logic         front_blue,
    output logic         front_red,
    output logic [4:0]   drv_blue,
    output logic [4:0]   drv_red
);

    localparam int ADDR_W      = 3;
    localparam int NUM_DRV     = (2 ** ADDR_W) - 3;
    localparam int NUM_CH      = NUM_DRV + 1;
    localparam int PWM_STEPS   = (2 ** FIELD_W) - 1;
    localparam int PWM_W       = FIELD_W;
    localparam int STRETCH_CYC = CLK_HZ / 20;

    typedef struct packed {
        logic [FIELD_W-1:0] front_lvl;
        logic [FIELD_W-1:0] drv_lvl;
    } bright_t;

    logic               wr_en;
    logic [ADDR_W-1:0]  wr_addr;
    logic [FIELD_W-1:0] wr_data;
    logic               tick;
    logic [PWM_W-1:0]   pwm_cnt;
    logic [NUM_CH-1:0]  mode_wr;
    logic [NUM_CH-1:0]  ch_blue;
    logic [NUM_CH-1:0]  ch_red;
    bright_t            br_d, br_q;

    ledctl_bus_sync #(.ADDR_W(ADDR_W), .DATA_W(FIELD_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_data (bus_data),
        .bus_en   (bus_en),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    ledctl_timebase #(.CLK_HZ(CLK_HZ), .PWM_STEPS(PWM_STEPS), .PWM_W(PWM_W)) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .pwm_cnt (pwm_cnt)
    );

    always_comb begin
        br_d = br_q;
        if (wr_en && wr_addr == 3'd1) br_d.front_lvl = wr_data;
        if (wr_en && wr_addr == 3'd2) br_d.drv_lvl   = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) br_q <= '{front_lvl: '1, drv_lvl: '1};
        else        br_q <= br_d;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        if (g == 0) begin : g_front
            assign mode_wr[g] = wr_en && (wr_addr == 3'd0);
            ledctl_channel #(.IS_DRIVE(1'b0), .STRETCH_CYC(STRETCH_CYC), .PWM_W(PWM_W)) u_ch (
                .clk     (clk),
                .rst_n   (rst_n),
                .tick    (tick),
                .pwm_cnt (pwm_cnt),
                .mode_wr (mode_wr[g]),
                .wr_data (wr_data),
                .level   (br_q.front_lvl),
                .act_n   (1'b1),
                .blue_o  (ch_blue[g]),
                .red_o   (ch_red[g])
            );
        end else begin : g_drive
            assign mode_wr[g] = wr_en && (wr_addr == ADDR_W'(g + 2));
            ledctl_channel #(.IS_DRIVE(1'b1), .STRETCH_CYC(STRETCH_CYC), .PWM_W(PWM_W)) u_ch (
                .clk     (clk),
                .rst_n   (rst_n),
                .tick    (tick),
                .pwm_cnt (pwm_cnt),
                .mode_wr (mode_wr[g]),
                .wr_data (wr_data),
                .level   (br_q.drv_lvl),
                .act_n   (act_n[g-1]),
                .blue_o  (ch_blue[g]),
                .red_o   (ch_red[g])
            );
        end
    end

    assign front_blue = ch_blue[0];
    assign front_red  = ch_red[0];
    assign drv_blue   = ch_blue[NUM_CH-1:1];
    assign drv_red    = ch_red[NUM_CH-1:1];

    // R2
    one_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mode_wr));

endmodule

// File: tb/tb_led_pattern_ctrl.sv
`timescale 1ns/1ps
module tb_led_pattern_ctrl;

    localparam int CLK_HZ = 400;
    localparam int H      = CLK_HZ / 2;
    localparam int S      = CLK_HZ / 20;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] bus_addr;
    logic [2:0] bus_data;
    logic       bus_en;
    logic [4:0] act_n;
    logic       front_blue, front_red;
    logic [4:0] drv_blue, drv_red;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    led_pattern_ctrl #(.CLK_HZ(CLK_HZ)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_data   (bus_data),
        .bus_en     (bus_en),
        .act_n      (act_n),
        .front_blue (front_blue),
        .front_red  (front_red),
        .drv_blue   (drv_blue),
        .drv_red    (drv_red)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // sel 0 = front, 1..5 = drive sel-1
    function automatic logic led_b(input int sel);
        return (sel == 0) ? front_blue : drv_blue[sel-1];
    endfunction
    function automatic logic led_r(input int sel);
        return (sel == 0) ? front_red : drv_red[sel-1];
    endfunction

    task automatic count_win(input int sel, input int n, output int nb, output int nr, output int nboth);
        nb = 0; nr = 0; nboth = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (led_b(sel)) nb++;
            if (led_r(sel)) nr++;
            if (led_b(sel) && led_r(sel)) nboth++;
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [2:0] d);
        @(negedge clk);
        bus_addr = a; bus_data = d;
        @(negedge clk);
        bus_en = 1'b1;
        repeat (3) @(negedge clk);
        bus_en = 1'b0;
        repeat (7) @(negedge clk);
    endtask

    task automatic t_reset();
        int nb, nr, nx, tot;
        tot = 0;
        for (int s = 0; s < 6; s++) begin
            count_win(s, 10, nb, nr, nx);
            tot += nb + nr;
        end
        chk("R3", "outputs lit after reset", tot, 0);
        bus_write(3'd0, 3'd1);
        count_win(0, 70, nb, nr, nx);
        chk("R3", "front default brightness full", nb, 70);
        bus_write(3'd3, 3'd7);
        count_win(1, 70, nb, nr, nx);
        chk("R3", "drive default brightness full", nb, 70);
        bus_write(3'd3, 3'd0);
    endtask

    task automatic t_front_steady();
        int nb, nr, nx;
        bus_write(3'd0, 3'd2);
        count_win(0, 70, nb, nr, nx);
        chk("R4", "mode 2 red", nr, 70);
        chk("R4", "mode 2 blue", nb, 0);
        bus_write(3'd0, 3'd0);
        count_win(0, 70, nb, nr, nx);
        chk("R4", "mode 0 lit", nb + nr, 0);
    endtask

    task automatic t_patterns();
        int nb, nr, nx;
        bus_write(3'd0, 3'd3);
        chk("R5", "mode 3 starts blue", int'(front_blue), 1);
        count_win(0, 4*H, nb, nr, nx);
        chk("R5", "mode 3 blue", nb, 2*H);
        chk("R5", "mode 3 red", nr, 0);
        bus_write(3'd0, 3'd4);
        chk("R5", "mode 4 starts red", int'(front_red), 1);
        count_win(0, 4*H, nb, nr, nx);
        chk("R5", "mode 4 red", nr, 2*H);
        chk("R5", "mode 4 blue", nb, 0);
        bus_write(3'd0, 3'd5);
        count_win(0, 6*H, nb, nr, nx);
        chk("R5", "mode 5 blue", nb, 5*H);
        chk("R5", "mode 5 red", nr, H);
        bus_write(3'd0, 3'd6);
        count_win(0, 4*H, nb, nr, nx);
        chk("R5", "mode 6 blue", nb, 2*H);
        chk("R5", "mode 6 red", nr, 2*H);
        chk("R10", "mode 6 both colours", nx, 0);
        bus_write(3'd0, 3'd7);
        count_win(0, 6*H, nb, nr, nx);
        chk("R5", "mode 7 blue", nb, H);
        chk("R5", "mode 7 red", nr, 0);
        bus_write(3'd0, 3'd0);
        // drive 4 at address 7, drive 1 at address 4
        bus_write(3'd7, 3'd5);
        count_win(5, 6*H, nb, nr, nx);
        chk("R5", "drive 4 mode 5 blue", nb, 5*H);
        chk("R5", "drive 4 mode 5 red", nr, H);
        chk("R10", "drive 4 both colours", nx, 0);
        bus_write(3'd7, 3'd0);
        bus_write(3'd4, 3'd4);
        count_win(2, 4*H, nb, nr, nx);
        chk("R5", "drive 1 mode 4 red", nr, 2*H);
        bus_write(3'd4, 3'd0);
    endtask

    task automatic t_restart();
        int nb, nr, nx, waited;
        bus_write(3'd0, 3'd3);
        waited = 0;
        while (front_blue && waited < 3*H) begin
            @(negedge clk);
            waited++;
        end
        chk("R6", "mode 3 reaches off phase", int'(front_blue), 0);
        bus_write(3'd0, 3'd3);
        chk("R6", "blue right after rewrite", int'(front_blue), 1);
        count_win(0, H - 20, nb, nr, nx);
        chk("R6", "blue held after restart", nb, H - 20);
        bus_write(3'd0, 3'd0);
    endtask

    task automatic t_drive_modes();
        int nb, nr, nx, other;
        bus_write(3'd5, 3'd2);
        count_win(3, 70, nb, nr, nx);
        chk("R7", "drive 2 mode 2 red", nr, 70);
        other = 0;
        for (int s = 0; s < 6; s++) begin
            if (s != 3) begin
                count_win(s, 7, nb, nr, nx);
                other += nb + nr;
            end
        end
        chk("R2", "write to address 5 lit other LEDs", other, 0);
        bus_write(3'd5, 3'd7);
        count_win(3, 70, nb, nr, nx);
        chk("R7", "drive 2 mode 7 steady blue", nb, 70);
        chk("R7", "drive 2 mode 7 red", nr, 0);
        bus_write(3'd5, 3'd0);
    endtask

    task automatic t_activity();
        int nb, nr, nx;
        bus_write(3'd3, 3'd1);
        bus_write(3'd4, 3'd1);
        count_win(1, 40, nb, nr, nx);
        chk("R7", "activity mode idle", nb, 0);
        @(negedge clk); act_n[0] = 1'b0;
        @(negedge clk); act_n[0] = 1'b1;
        count_win(1, 5*S, nb, nr, nx);
        chk("R8", "single pulse on time", nb, S);
        @(negedge clk); act_n[0] = 1'b0;
        repeat (5) @(negedge clk);
        count_win(1, 10*S, nb, nr, nx);
        chk("R8", "continuous activity duty", nb, 5*S);
        count_win(2, 40, nb, nr, nx);
        chk("R8", "drive 1 lit by drive 0 activity", nb, 0);
        act_n[0] = 1'b1;
        repeat (3*S) @(negedge clk);
        count_win(1, 2*S, nb, nr, nx);
        chk("R8", "idle after activity stops", nb, 0);
        bus_write(3'd3, 3'd0);
        bus_write(3'd4, 3'd0);
    endtask

    task automatic t_pwm();
        int nb, nr, nx;
        bus_write(3'd0, 3'd1);
        bus_write(3'd1, 3'd3);
        count_win(0, 70, nb, nr, nx);
        chk("R9", "front brightness 3", nb, 30);
        bus_write(3'd1, 3'd0);
        count_win(0, 70, nb, nr, nx);
        chk("R9", "front brightness 0", nb, 0);
        bus_write(3'd1, 3'd7);
        bus_write(3'd3, 3'd7);
        bus_write(3'd2, 3'd2);
        count_win(1, 70, nb, nr, nx);
        chk("R9", "drive brightness 2", nb, 20);
        count_win(0, 70, nb, nr, nx);
        chk("R2", "drive brightness touched front", nb, 70);
        bus_write(3'd2, 3'd7);
        bus_write(3'd3, 3'd0);
        bus_write(3'd0, 3'd0);
    endtask

    task automatic t_strobe_held();
        int nb, nr, nx;
        @(negedge clk);
        bus_addr = 3'd0; bus_data = 3'd1;
        @(negedge clk);
        bus_en = 1'b1;
        repeat (6) @(negedge clk);
        bus_addr = 3'd1; bus_data = 3'd2;
        repeat (6) @(negedge clk);
        bus_en = 1'b0;
        repeat (6) @(negedge clk);
        count_win(0, 70, nb, nr, nx);
        chk("R1", "front blue after held strobe", nb, 70);
        chk("R1", "front red after held strobe", nr, 0);
        bus_write(3'd0, 3'd0);
    endtask

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_data = '0; bus_en = 1'b0; act_n = '1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_front_steady();
        t_patterns();
        t_restart();
        t_drive_modes();
        t_activity();
        t_pwm();
        t_strobe_held();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule